// File: doc/BRIEF.md
# Privilege and Memory Guard with Preemption Timer

This block sits beside a simple processor core and decides, cycle by cycle, what the running program may do. It holds one privilege bit (kernel or user), a window register pair that bounds user memory accesses, a down-counting preemption timer and a set of latched external interrupt lines. Every cycle it looks at the presented memory access, the class of the instruction in flight and any pending interrupt. It then grants or refuses the access and, if needed, raises a trap with a cause code.

Taking any trap or interrupt drops the core into kernel mode and records the program counter of the interrupted instruction. It also marks the block as servicing, which holds back every further interrupt until the kernel issues a return strobe. The return strobe puts the core back in user mode. Interrupts that arrive in the meantime stay latched and are delivered one at a time after the return.

Top module: `prot_unit`

## Requirements
- R1: After reset the block is in kernel mode (`user_mode`=0), `in_service` is 0, no trap is requested, the window registers are zero and the timer is idle.
- R2: In kernel mode every valid access is granted and no access ever raises a trap.
- R3: In user mode a valid access is granted exactly when base <= address < base + size. The upper bound is formed with one extra bit, so a window that reaches the top of the address space does not wrap to low addresses.
- R4: A valid user-mode access outside the window is refused (`acc_grant`=0) and raises `trap_req` in the same cycle with cause code 1 (bounds).
- R5: In user mode, a privileged instruction (`insn_priv`), an I/O instruction (`insn_io`) or a return strobe (`trap_ret`) raises `trap_req` with cause code 0 (privileged). A return strobe from user mode does not leave the block in user mode.
- R6: The base, size and timer write strobes take effect only in kernel mode. In user mode each one raises a trap with cause code 0 and leaves the register it targets unchanged.
- R7: A nonzero timer value N loaded in kernel mode counts down by one per clock. In the cycle after the count reaches zero (N cycles after the load edge) an unmasked timer interrupt is requested with cause code 2.
- R8: While `in_service` is 1 no trap is requested. Timer expiries and external requests that arrive meanwhile stay pending and are delivered after the return strobe.
- R9: When several events compete in one cycle, the priority is privileged, then bounds, then timer, then external. Among external lines the lowest index is taken first, reported on `trap_irq` with cause code 3, and only that line is cleared.
- R10: A return strobe in kernel mode with no trap in the same cycle sets user mode and clears `in_service` at the next edge.
- R11: Whenever a trap is taken, the next cycle shows kernel mode, `in_service`=1 and `epc` equal to the `pc_in` of the trapping cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Memory access presented this cycle |
| acc_addr | input | AW | Physical address of the access |
| acc_write | input | 1 | Access is a store (no effect on the check) |
| insn_priv | input | 1 | Instruction in flight is privileged |
| insn_io | input | 1 | Instruction in flight is an I/O instruction |
| pc_in | input | PCW | Program counter of the instruction in flight |
| irq_req | input | NIRQ | External interrupt request lines, latched when high |
| trap_ret | input | 1 | Return-from-trap strobe |
| wr_base | input | 1 | Load window base from `wr_data` |
| wr_limit | input | 1 | Load window size from `wr_data` |
| wr_data | input | AW | Data for base or size loads |
| wr_timer | input | 1 | Load timer from `tmr_data` |
| tmr_data | input | TW | Timer load value |
| acc_grant | output | 1 | Access permitted |
| trap_req | output | 1 | Trap taken this cycle |
| trap_cause | output | 2 | 0 privileged, 1 bounds, 2 timer, 3 external |
| trap_irq | output | IW | Line index for cause 3 |
| epc | output | PCW | Saved program counter of the last trap |
| user_mode | output | 1 | 1 user mode, 0 kernel mode |
| in_service | output | 1 | Trap being serviced, interrupts masked |

## Verification
The hardest situation to reach is several events competing while interrupts are masked. Examples are a timer expiry and external lines arriving during service, or an external request becoming pending in the same cycle that a privileged fault occurs. The bench enters service through a deliberate privileged fault and loads short timer values from there. It pulses external lines while the mask holds and then releases it with return strobes, one delivery at a time. To set up the fault-over-interrupt collision, an external pulse is placed one cycle ahead of a privileged instruction, so that the request is pending exactly when the fault arrives.

// File: rtl/prot_unit.sv
module prot_unit #(
  parameter int AW   = 16,
  parameter int PCW  = 16,
  parameter int TW   = 16,
  parameter int NIRQ = 4,
  localparam int IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic            acc_write,
  input  logic            insn_priv,
  input  logic            insn_io,
  input  logic [PCW-1:0]  pc_in,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            trap_ret,
  input  logic            wr_base,
  input  logic            wr_limit,
  input  logic [AW-1:0]   wr_data,
  input  logic            wr_timer,
  input  logic [TW-1:0]   tmr_data,
  output logic            acc_grant,
  output logic            trap_req,
  output logic [1:0]      trap_cause,
  output logic [IW-1:0]   trap_irq,
  output logic [PCW-1:0]  epc,
  output logic            user_mode,
  output logic            in_service
);

  localparam logic [1:0] C_PRIV = 2'd0;
  localparam logic [1:0] C_BND  = 2'd1;
  localparam logic [1:0] C_TMR  = 2'd2;
  localparam logic [1:0] C_EXT  = 2'd3;

  logic [AW-1:0]   base_q, size_q;
  logic [TW-1:0]   tmr_q;
  logic            tmr_pend;
  logic [NIRQ-1:0] irq_pend;
  logic [IW-1:0]   irq_sel;
  logic [NIRQ-1:0] irq_oh;

  logic [AW:0] upper;
  logic        in_win, cfg_wr, priv_hit, bnd_hit, take_tmr, take_ext, kern;
  logic        tmr_load, tmr_fire;

  assign upper    = {1'b0, base_q} + {1'b0, size_q};
  assign in_win   = (acc_addr >= base_q) && ({1'b0, acc_addr} < upper);
  assign kern     = !user_mode;
  assign cfg_wr   = wr_base | wr_limit | wr_timer;
  assign priv_hit = user_mode && (insn_priv | insn_io | cfg_wr | trap_ret);
  assign bnd_hit  = user_mode && acc_valid && !in_win;
  assign take_tmr = !in_service && tmr_pend && !priv_hit && !bnd_hit;
  assign take_ext = !in_service && (|irq_pend) && !tmr_pend && !priv_hit && !bnd_hit;

  assign acc_grant = acc_valid && (kern || in_win);
  assign trap_req  = priv_hit | bnd_hit | take_tmr | take_ext;
  assign trap_irq  = irq_sel;

  always_comb begin
    if (priv_hit)      trap_cause = C_PRIV;
    else if (bnd_hit)  trap_cause = C_BND;
    else if (take_tmr) trap_cause = C_TMR;
    else               trap_cause = C_EXT;
  end

  always_comb begin
    irq_sel = '0;
    irq_oh  = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (irq_pend[i]) begin
        irq_sel   = IW'(i);
        irq_oh    = '0;
        irq_oh[i] = 1'b1;
      end
    end
  end

  assign tmr_load = kern && wr_timer;
  assign tmr_fire = !tmr_load && (tmr_q == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else begin
      if (kern && wr_base)  base_q <= wr_data;
      if (kern && wr_limit) size_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      tmr_pend <= 1'b0;
    end else begin
      if (tmr_load)          tmr_q <= tmr_data;
      else if (tmr_q != '0)  tmr_q <= tmr_q - TW'(1);
      tmr_pend <= (tmr_pend && !take_tmr) || tmr_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pend <= '0;
    else        irq_pend <= (irq_pend & ~(take_ext ? irq_oh : '0)) | irq_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_mode  <= 1'b0;
      in_service <= 1'b0;
      epc        <= '0;
    end else if (trap_req) begin
      user_mode  <= 1'b0;
      in_service <= 1'b1;
      epc        <= pc_in;
    end else if (trap_ret) begin
      user_mode  <= 1'b1;
      in_service <= 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = acc_write;

endmodule

// File: rtl/prot_unit_chk.sv
module prot_unit_chk #(
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_valid,
  input logic           acc_grant,
  input logic           user_mode,
  input logic           in_service,
  input logic           trap_req,
  input logic [1:0]     trap_cause,
  input logic           trap_ret,
  input logic           insn_priv,
  input logic           insn_io,
  input logic           wr_base,
  input logic           wr_limit,
  input logic           wr_timer,
  input logic [PCW-1:0] pc_in,
  input logic [PCW-1:0] epc
);

  // R2
  kern_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !user_mode) |-> (acc_grant && !trap_req));

  // R4
  refuse_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && user_mode && !acc_grant) |-> trap_req);

  // R5
  priv_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && (insn_priv || insn_io || trap_ret)) |-> (trap_req && trap_cause == 2'd0));

  // R6
  cfg_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && (wr_base || wr_limit || wr_timer)) |-> (trap_req && trap_cause == 2'd0));

  // R8
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> !trap_req);

  // R10
  ret_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !user_mode && !trap_req) |=> (user_mode && !in_service));

  // R11
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (!user_mode && in_service && epc == $past(pc_in)));

endmodule

bind prot_unit prot_unit_chk #(.PCW(PCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_grant(acc_grant),
  .user_mode(user_mode), .in_service(in_service), .trap_req(trap_req),
  .trap_cause(trap_cause), .trap_ret(trap_ret), .insn_priv(insn_priv),
  .insn_io(insn_io), .wr_base(wr_base), .wr_limit(wr_limit),
  .wr_timer(wr_timer), .pc_in(pc_in), .epc(epc)
);

// File: tb/prot_unit_tb_top.sv
module prot_unit_tb_top;
  localparam int AW = 16, PCW = 16, TW = 16, NIRQ = 4, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, insn_priv = 0, insn_io = 0, trap_ret = 0;
  logic wr_base = 0, wr_limit = 0, wr_timer = 0;
  logic [AW-1:0] acc_addr = '0, wr_data = '0;
  logic [PCW-1:0] pc_in = '0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [TW-1:0] tmr_data = '0;
  logic acc_grant, trap_req, user_mode, in_service;
  logic [1:0] trap_cause;
  logic [IW-1:0] trap_irq;
  logic [PCW-1:0] epc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prot_unit #(.AW(AW), .PCW(PCW), .TW(TW), .NIRQ(NIRQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .insn_priv(insn_priv), .insn_io(insn_io),
    .pc_in(pc_in), .irq_req(irq_req), .trap_ret(trap_ret),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_data(wr_data),
    .wr_timer(wr_timer), .tmr_data(tmr_data), .acc_grant(acc_grant),
    .trap_req(trap_req), .trap_cause(trap_cause), .trap_irq(trap_irq),
    .epc(epc), .user_mode(user_mode), .in_service(in_service));

  // {address, expected grant} with window 0x1000 .. 0x10FF
  localparam logic [16:0] VEC [8] = '{
    {16'h1000, 1'b1}, {16'h10FF, 1'b1}, {16'h1100, 1'b0}, {16'h0FFF, 1'b0},
    {16'h1080, 1'b1}, {16'h0000, 1'b0}, {16'hFFFF, 1'b0}, {16'h1001, 1'b1}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ret_once();
    trap_ret = 1'b1;
    @(negedge clk);
    trap_ret = 1'b0;
  endtask

  task automatic to_kernel();
    insn_priv = 1'b1;
    @(negedge clk);
    insn_priv = 1'b0;
  endtask

  task automatic set_window(input logic [AW-1:0] b, input logic [AW-1:0] s);
    wr_base = 1'b1; wr_data = b;
    @(negedge clk);
    wr_base = 1'b0; wr_limit = 1'b1; wr_data = s;
    @(negedge clk);
    wr_limit = 1'b0;
  endtask

  task automatic exp_trap(input string tag, input logic [1:0] cause);
    #3;
    chk(trap_req === 1'b1, tag, 32'(trap_req), 32'd1);
    chk(trap_cause === cause, tag, 32'(trap_cause), 32'(cause));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk(user_mode === 1'b0, "R1 mode", 32'(user_mode), 0);
    chk(in_service === 1'b0, "R1 service", 32'(in_service), 0);
    chk(trap_req === 1'b0, "R1 trap", 32'(trap_req), 0);

    acc_valid = 1'b1; acc_addr = 16'hFFFF; acc_write = 1'b1;
    #1;
    chk(acc_grant === 1'b1, "R2 kernel grant", 32'(acc_grant), 1);
    chk(trap_req === 1'b0, "R2 kernel no trap", 32'(trap_req), 0);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;

    set_window(16'h1000, 16'h0100);
    ret_once();
    #3;
    chk(user_mode === 1'b1, "R10 user", 32'(user_mode), 1);
    chk(in_service === 1'b0, "R10 service", 32'(in_service), 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = VEC[i][16:1]; pc_in = PCW'(16'h40 + i);
      #3;
      chk(acc_grant === VEC[i][0], "R3 window grant", 32'(acc_grant), 32'(VEC[i][0]));
      chk(trap_req === !VEC[i][0], "R4 bounds trap", 32'(trap_req), 32'(!VEC[i][0]));
      if (!VEC[i][0]) chk(trap_cause === 2'd1, "R4 cause", 32'(trap_cause), 1);
      @(negedge clk);
      acc_valid = 1'b0;
      if (!VEC[i][0]) begin
        #3;
        chk(!user_mode && in_service, "R11 entry", {user_mode, in_service}, 32'b01);
        chk(epc === PCW'(16'h40 + i), "R11 epc", 32'(epc), 32'(16'h40 + i));
        @(negedge clk);
        ret_once();
      end
    end

    @(negedge clk);
    insn_priv = 1'b1; pc_in = 16'h200;
    exp_trap("R5 priv", 2'd0);
    @(negedge clk); insn_priv = 1'b0; ret_once();
    insn_io = 1'b1;
    exp_trap("R5 io", 2'd0);
    @(negedge clk); insn_io = 1'b0; ret_once();
    trap_ret = 1'b1;
    exp_trap("R5 ret from user", 2'd0);
    @(negedge clk); trap_ret = 1'b0;
    #3;
    chk(!user_mode && in_service, "R5 stays kernel", {user_mode, in_service}, 32'b01);
    @(negedge clk); ret_once();

    wr_base = 1'b1; wr_data = 16'h0000;
    exp_trap("R6 base write", 2'd0);
    @(negedge clk); wr_base = 1'b0; ret_once();
    acc_valid = 1'b1; acc_addr = 16'h0FFF;
    #3;
    chk(acc_grant === 1'b0, "R6 base unchanged", 32'(acc_grant), 0);
    @(negedge clk); acc_valid = 1'b0; ret_once();
    wr_timer = 1'b1; tmr_data = 16'd3;
    exp_trap("R6 timer write", 2'd0);
    @(negedge clk); wr_timer = 1'b0; ret_once();
    for (int i = 0; i < 6; i++) begin
      #3;
      chk(trap_req === 1'b0, "R6 timer not loaded", 32'(trap_req), 0);
      @(negedge clk);
    end

    to_kernel();
    wr_timer = 1'b1; tmr_data = 16'd5;
    @(negedge clk); wr_timer = 1'b0; trap_ret = 1'b1;
    @(negedge clk); trap_ret = 1'b0; pc_in = 16'h300;
    for (int i = 1; i < 5; i++) begin
      #3;
      chk(trap_req === 1'b0, "R7 early", 32'(trap_req), 0);
      @(negedge clk);
    end
    exp_trap("R7 expiry", 2'd2);
    @(negedge clk);
    #3;
    chk(in_service === 1'b1, "R7 service", 32'(in_service), 1);
    chk(epc === 16'h300, "R11 timer epc", 32'(epc), 32'h300);

    @(negedge clk);
    wr_timer = 1'b1; tmr_data = 16'd2;
    @(negedge clk); wr_timer = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #3;
      chk(trap_req === 1'b0, "R8 timer masked", 32'(trap_req), 0);
      @(negedge clk);
    end
    ret_once();
    exp_trap("R8 timer after return", 2'd2);
    @(negedge clk);

    irq_req = 4'b0110;
    @(negedge clk); irq_req = '0;
    for (int i = 0; i < 3; i++) begin
      #3;
      chk(trap_req === 1'b0, "R8 external masked", 32'(trap_req), 0);
      @(negedge clk);
    end
    ret_once();
    exp_trap("R9 lowest line", 2'd3);
    chk(trap_irq === 2'd1, "R9 line 1", 32'(trap_irq), 1);
    @(negedge clk); ret_once();
    exp_trap("R9 next line", 2'd3);
    chk(trap_irq === 2'd2, "R9 line 2", 32'(trap_irq), 2);
    @(negedge clk); ret_once();
    #3;
    chk(trap_req === 1'b0 && user_mode === 1'b1, "R10 drained", {trap_req, user_mode}, 32'b01);

    @(negedge clk);
    to_kernel();
    wr_timer = 1'b1; tmr_data = 16'd1; irq_req = 4'b0001;
    @(negedge clk); wr_timer = 1'b0; irq_req = '0;
    repeat (3) @(negedge clk);
    ret_once();
    exp_trap("R9 timer first", 2'd2);
    @(negedge clk); ret_once();
    exp_trap("R9 external second", 2'd3);
    chk(trap_irq === 2'd0, "R9 line 0", 32'(trap_irq), 0);
    @(negedge clk); ret_once();

    irq_req = 4'b1000;
    @(negedge clk); irq_req = '0; insn_priv = 1'b1;
    exp_trap("R9 fault over interrupt", 2'd0);
    @(negedge clk); insn_priv = 1'b0; ret_once();
    exp_trap("R9 held interrupt", 2'd3);
    chk(trap_irq === 2'd3, "R9 line 3", 32'(trap_irq), 3);
    @(negedge clk); ret_once();

    insn_priv = 1'b1; acc_valid = 1'b1; acc_addr = 16'h0000;
    exp_trap("R9 priv over bounds", 2'd0);
    chk(acc_grant === 1'b0, "R9 refused", 32'(acc_grant), 0);
    @(negedge clk); insn_priv = 1'b0; acc_valid = 1'b0;

    set_window(16'hFFF0, 16'h0020);
    ret_once();
    acc_valid = 1'b1; acc_addr = 16'hFFF8;
    #3;
    chk(acc_grant === 1'b1 && trap_req === 1'b0, "R3 top of space", {acc_grant, trap_req}, 32'b10);
    @(negedge clk); acc_addr = 16'h0005;
    exp_trap("R3 no wrap", 2'd1);
    chk(acc_grant === 1'b0, "R3 low refused", 32'(acc_grant), 0);
    @(negedge clk); acc_valid = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule